// File: doc/BRIEF.md
# SPI DMA Transfer Segment Planner

This block breaks one long SPI transfer of 64-bit words into a series of segments, each of which a downstream DMA engine carries out as a whole number of equal-sized DMA bursts. A single-cycle start pulse loads the total word count. The block then offers one descriptor at a time on a valid/ready handshake. Each descriptor holds the segment length in words, the DMA burst length minus one, and the number of DMA bursts.

The burst length is picked so that the engine is never asked for a one-word burst, because a single word cannot raise a DMA request. Short tails stay inside the FIFO. Longer lengths are matched to the largest burst size from eight down to two that divides them evenly. When no size divides evenly, the length is trimmed to a multiple of eight, and the trim is made so that the piece left over is never a single word. A transfer shorter than two words is refused with an error pulse. A one-cycle done pulse follows acceptance of the last descriptor.

Top module: `spi_seg_planner`

## Requirements
- R1: After reset, desc_valid_o, done_o and err_o are all low.
- R2: If the remaining count is at most FIFO_DEPTH (default 8), the segment is the whole remainder, the burst length equals the remainder, and the burst count is 1.
- R3: Otherwise, if some size d from 8 down to 2 divides the remainder exactly with a quotient that fits BC_W bits, the largest such d is the burst length, the segment is the whole remainder, and the burst count is remainder/d.
- R4: Otherwise the burst length is 8, and the segment is the remainder minus (remainder mod 8); when that modulus is 1, 8 further words are removed.
- R5: The largest segment is MAX = 8*(2^BC_W-1) words (524280 by default). A remainder of exactly MAX+1 gives a segment of MAX-8, and any other remainder of at least MAX gives a segment of MAX. Both use burst length 8.
- R6: burst_len_m1_o carries the burst length minus one, and burst_cnt_o carries ceil(segment/burst length) in BC_W bits.
- R7: A start with a total below 2 raises err_o for exactly the next cycle and produces no descriptor.
- R8: While desc_valid_o is high and desc_ready_i is low, all descriptor fields stay unchanged. The remaining count moves only on an accepted descriptor.
- R9: done_o is high for exactly the one cycle after the last descriptor is accepted, and desc_valid_o is low in that cycle.
- R10: A start pulse while a plan is in progress is ignored.
- R11: The accepted segments add up exactly to the total, and no descriptor has a burst length below 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; loads total_words_i when idle |
| total_words_i | input | CNT_W | Total transfer length in 64-bit words |
| desc_valid_o | output | 1 | A descriptor is offered |
| desc_ready_i | input | 1 | Downstream accepts the descriptor |
| seg_len_o | output | CNT_W | Segment length in words |
| burst_len_m1_o | output | BLEN_W | DMA burst length minus one |
| burst_cnt_o | output | BC_W | Number of DMA bursts in the segment |
| done_o | output | 1 | One-cycle pulse after the last descriptor is accepted |
| err_o | output | 1 | One-cycle pulse for a rejected start |

## Verification
A corrupt remaining count shows at the ports as early as the next descriptor. The segment length or burst length there departs from what the remainder implies, and the sum of accepted segments misses the total, so done_o comes early, late, or not at all. A broken priority in the divisor search or in the trim rule changes burst_len_m1_o in the same cycle that the affected remainder is offered. The bench therefore checks every descriptor of every plan against its own model of the rules, and not just the first descriptor. A stuck busy state shows at once as an ignored valid start or a missing done pulse.

// File: rtl/spi_seg_pkg.sv
// Package: shared constants, state type and width helper for the planner.
// Assumes DMA bursts are counted in 64-bit words.
package spi_seg_pkg;

    // Default and largest DMA burst length in words.
    localparam int BLEN_DEF = 8;

    // Planner state.
    typedef enum logic {
        PL_IDLE = 1'b0,
        PL_RUN  = 1'b1
    } plan_state_e;

    // Width of the burst-length-minus-one field for a given FIFO depth.
    function automatic int blen_width(input int fifo_depth);
        int top;
        top = (fifo_depth > BLEN_DEF) ? fifo_depth : BLEN_DEF;
        return $clog2(top);
    endfunction

endpackage

// File: rtl/spi_seg_divsel.sv
// Module: spi_seg_divsel
// Finds the largest burst size from DMAX down to 2 that divides the
// remaining count exactly and whose quotient fits a BC_W-bit burst count.
// Purely combinational. Assumes DMAX >= 2.
module spi_seg_divsel #(
    parameter int CNT_W = 24,
    parameter int BC_W  = 16,
    parameter int DMAX  = 8,
    localparam int DW   = $clog2(DMAX + 1)
) (
    input  logic [CNT_W-1:0] rem_i,
    output logic             hit_o,
    output logic [DW-1:0]    div_o,
    output logic [BC_W-1:0]  quo_o
);

    localparam logic [CNT_W-1:0] QMAX = CNT_W'((2 ** BC_W) - 1);

    logic [DMAX:2]   fit;
    logic [BC_W-1:0] quo [DMAX:2];

    // One exact-division test per candidate burst size.
    for (genvar g = 2; g <= DMAX; g++) begin : g_div
        localparam logic [CNT_W-1:0] DV = CNT_W'(g);
        logic [CNT_W-1:0] q;
        assign q      = rem_i / DV;
        assign fit[g] = ((rem_i % DV) == '0) && (q <= QMAX);
        assign quo[g] = BC_W'(q);
    end

    // Priority pick: later (larger) candidates override smaller ones.
    always_comb begin
        hit_o = 1'b0;
        div_o = '0;
        quo_o = '0;
        for (int k = 2; k <= DMAX; k++) begin
            if (fit[k]) begin
                hit_o = 1'b1;
                div_o = DW'(k);
                quo_o = quo[k];
            end
        end
    end

endmodule

// File: rtl/spi_seg_calc.sv
// Module: spi_seg_calc
// Turns a remaining word count into one segment descriptor: length,
// burst length minus one, and burst count. Combinational. Assumes the
// remaining count is at least 2 whenever its outputs are used.
module spi_seg_calc
    import spi_seg_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = 24,
    parameter int BC_W       = 16,
    localparam int BLEN_W    = blen_width(FIFO_DEPTH)
) (
    input  logic [CNT_W-1:0]  rem_i,
    output logic [CNT_W-1:0]  seg_o,
    output logic [BLEN_W-1:0] blen_m1_o,
    output logic [BC_W-1:0]   bcnt_o
);

    localparam int               SH      = $clog2(BLEN_DEF);
    localparam int               DW      = $clog2(BLEN_DEF + 1);
    localparam logic [CNT_W-1:0] MAX_SEG = CNT_W'(BLEN_DEF * ((2 ** BC_W) - 1));
    localparam logic [CNT_W-1:0] MAX_P1  = MAX_SEG + CNT_W'(1);
    localparam logic [CNT_W-1:0] LIM_M8  = MAX_SEG - CNT_W'(BLEN_DEF);
    localparam logic [CNT_W-1:0] FIFO_C  = CNT_W'(FIFO_DEPTH);

    logic             div_hit;
    logic [DW-1:0]    div_sel;
    logic [BC_W-1:0]  div_quo;
    logic [CNT_W-1:0] trim_w;

    spi_seg_divsel #(
        .CNT_W (CNT_W),
        .BC_W  (BC_W),
        .DMAX  (BLEN_DEF)
    ) u_divsel (
        .rem_i (rem_i),
        .hit_o (div_hit),
        .div_o (div_sel),
        .quo_o (div_quo)
    );

    // Round down to a burst multiple; drop one more burst if a lone word would remain.
    assign trim_w = {rem_i[CNT_W-1:SH], {SH{1'b0}}}
                  - ((rem_i[SH-1:0] == SH'(1)) ? CNT_W'(BLEN_DEF) : '0);

    // Rule priority: FIFO tail, max+1, cap, exact divisor, trim.
    always_comb begin
        if (rem_i <= FIFO_C) begin
            seg_o     = rem_i;
            blen_m1_o = BLEN_W'(rem_i - CNT_W'(1));
            bcnt_o    = BC_W'(1);
        end else if (rem_i == MAX_P1) begin
            seg_o     = LIM_M8;
            blen_m1_o = BLEN_W'(BLEN_DEF - 1);
            bcnt_o    = BC_W'(LIM_M8 >> SH);
        end else if (rem_i >= MAX_SEG) begin
            seg_o     = MAX_SEG;
            blen_m1_o = BLEN_W'(BLEN_DEF - 1);
            bcnt_o    = BC_W'(MAX_SEG >> SH);
        end else if (div_hit) begin
            seg_o     = rem_i;
            blen_m1_o = BLEN_W'(div_sel - DW'(1));
            bcnt_o    = div_quo;
        end else begin
            seg_o     = trim_w;
            blen_m1_o = BLEN_W'(BLEN_DEF - 1);
            bcnt_o    = BC_W'(trim_w >> SH);
        end
    end

endmodule

// File: rtl/spi_seg_planner.sv
// Module: spi_seg_planner (top)
// Holds the remaining word count of one transfer and offers one segment
// descriptor at a time on a valid/ready handshake. Pulses done after the
// last accept and err on a start shorter than two words.
// Assumes start_i is a single-cycle pulse; start while running is ignored.
module spi_seg_planner
    import spi_seg_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = 24,
    parameter int BC_W       = 16,
    localparam int BLEN_W    = blen_width(FIFO_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  total_words_i,
    output logic              desc_valid_o,
    input  logic              desc_ready_i,
    output logic [CNT_W-1:0]  seg_len_o,
    output logic [BLEN_W-1:0] burst_len_m1_o,
    output logic [BC_W-1:0]   burst_cnt_o,
    output logic              done_o,
    output logic              err_o
);

    localparam int               PW      = CNT_W + BC_W;
    localparam logic [CNT_W-1:0] MAX_SEG = CNT_W'(BLEN_DEF * ((2 ** BC_W) - 1));

    plan_state_e      state_q;
    logic [CNT_W-1:0] rem_q;
    logic             done_q;
    logic             err_q;
    logic             accept;

    spi_seg_calc #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .CNT_W      (CNT_W),
        .BC_W       (BC_W)
    ) u_calc (
        .rem_i     (rem_q),
        .seg_o     (seg_len_o),
        .blen_m1_o (burst_len_m1_o),
        .bcnt_o    (burst_cnt_o)
    );

    assign desc_valid_o = (state_q == PL_RUN);
    assign accept       = desc_valid_o && desc_ready_i;
    assign done_o       = done_q;
    assign err_o        = err_q;

    // Plan control: load on start, subtract on accept, pulse done and err.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PL_IDLE;
            rem_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (state_q == PL_IDLE) begin
                if (start_i) begin
                    if (total_words_i < CNT_W'(2)) begin
                        err_q <= 1'b1;
                    end else begin
                        state_q <= PL_RUN;
                        rem_q   <= total_words_i;
                    end
                end
            end else if (accept) begin
                rem_q <= rem_q - seg_len_o;
                if (rem_q == seg_len_o) begin
                    state_q <= PL_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    // Product of burst count and burst length, checked against the segment.
    logic [PW-1:0] cover_w;
    assign cover_w = PW'(burst_cnt_o) * (PW'(burst_len_m1_o) + PW'(1));

    // R8: an offered, unaccepted descriptor does not move.
    a_r8_hold_desc: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o && !desc_ready_i |=> desc_valid_o && $stable(seg_len_o)
            && $stable(burst_len_m1_o) && $stable(burst_cnt_o));

    // R8: the remaining count changes only through a handshake.
    a_r8_rem_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o && !desc_ready_i |=> $stable(rem_q));

    // R9: done lasts one cycle and never overlaps an offered descriptor.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !desc_valid_o);

    // R7: a rejected start leaves no descriptor and the error lasts one cycle.
    a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !desc_valid_o);
    a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R11: no one-word burst and no segment beyond what is left.
    a_r11_no_single: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o |-> (burst_len_m1_o != '0) && (seg_len_o <= rem_q)
            && (seg_len_o != '0));

    // R5: a segment never exceeds the cap.
    a_r5_cap: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o |-> seg_len_o <= MAX_SEG);

    // R6: bursts tile the segment exactly.
    a_r6_cover: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o |-> cover_w == PW'(seg_len_o));

    // R10: a start while running does not restart the plan.
    a_r10_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o && !desc_ready_i && start_i |=> $stable(rem_q));

endmodule

// File: tb/tb_spi_seg_planner.sv
`timescale 1ns/1ps
module tb_spi_seg_planner;

    localparam int CNT_W = 24;
    localparam int BC_W  = 16;
    localparam int MAXS  = 8 * 65535;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] total_words_i = '0;
    logic             desc_valid_o;
    logic             desc_ready_i = 1'b0;
    logic [CNT_W-1:0] seg_len_o;
    logic [2:0]       burst_len_m1_o;
    logic [BC_W-1:0]  burst_cnt_o;
    logic             done_o;
    logic             err_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    spi_seg_planner #(.FIFO_DEPTH(8), .CNT_W(CNT_W), .BC_W(BC_W)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .total_words_i  (total_words_i),
        .desc_valid_o   (desc_valid_o),
        .desc_ready_i   (desc_ready_i),
        .seg_len_o      (seg_len_o),
        .burst_len_m1_o (burst_len_m1_o),
        .burst_cnt_o    (burst_cnt_o),
        .done_o         (done_o),
        .err_o          (err_o)
    );

    // Columns: total, first segment, burst length, burst count, rule.
    localparam int NV = 14;
    localparam int VEC [NV][5] = '{
        '{2,      2,      2, 1,     2},
        '{8,      8,      8, 1,     2},
        '{9,      9,      3, 3,     3},
        '{16,     16,     8, 2,     3},
        '{14,     14,     7, 2,     3},
        '{25,     25,     5, 5,     3},
        '{10,     10,     5, 2,     3},
        '{17,     8,      8, 1,     4},
        '{13,     8,      8, 1,     4},
        '{23,     16,     8, 2,     4},
        '{262138, 262136, 8, 32767, 4},
        '{524281, 524272, 8, 65534, 5},
        '{600000, 524280, 8, 65535, 5},
        '{524280, 524280, 8, 65535, 5}
    };

    function automatic string rtag(input int n);
        case (n)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bench model of the segment rules (R2..R5).
    task automatic ref_seg(input int r, output int seg, output int bl, output int cnt);
        bit found = 0;
        if (r <= 8) begin
            seg = r; bl = r; cnt = 1;
        end else if (r == MAXS + 1) begin
            seg = MAXS - 8; bl = 8; cnt = seg / 8;
        end else if (r >= MAXS) begin
            seg = MAXS; bl = 8; cnt = MAXS / 8;
        end else begin
            seg = 0; bl = 8; cnt = 0;
            for (int d = 8; d >= 2; d--) begin
                if (!found && (r % d == 0) && (r / d <= 65535)) begin
                    found = 1; seg = r; bl = d; cnt = r / d;
                end
            end
            if (!found) begin
                seg = r - (r % 8);
                if (r % 8 == 1) seg = seg - 8;
                bl = 8; cnt = seg / 8;
            end
        end
    endtask

    task automatic pulse_start(input int total);
        total_words_i = CNT_W'(total);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Accept every descriptor of a plan; check each against the model, then done.
    task automatic drain(input int total);
        int rem = total;
        int guard = 0;
        int s, b, c;
        while (rem > 0 && guard < 16) begin
            guard++;
            ref_seg(rem, s, b, c);
            chk(desc_valid_o == 1'b1, "R11", int'(desc_valid_o), 1);
            chk(int'(seg_len_o) == s, "R11", int'(seg_len_o), s);
            chk(int'(burst_len_m1_o) == b - 1, "R6", int'(burst_len_m1_o), b - 1);
            chk(int'(burst_cnt_o) == c, "R6", int'(burst_cnt_o), c);
            chk(b >= 2, "R11", b, 2);
            rem = rem - s;
            desc_ready_i = 1'b1;
            @(negedge clk);
            desc_ready_i = 1'b0;
        end
        chk(done_o == 1'b1, "R9", int'(done_o), 1);
        chk(desc_valid_o == 1'b0, "R9", int'(desc_valid_o), 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R9", int'(done_o), 0);
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(desc_valid_o == 1'b0, "R1", int'(desc_valid_o), 0);
        chk(done_o == 1'b0, "R1", int'(done_o), 0);
        chk(err_o == 1'b0, "R1", int'(err_o), 0);

        // Table walk: first descriptor from the table, the rest from the model.
        for (int v = 0; v < NV; v++) begin
            pulse_start(VEC[v][0]);
            chk(int'(seg_len_o) == VEC[v][1], rtag(VEC[v][4]), int'(seg_len_o), VEC[v][1]);
            chk(int'(burst_len_m1_o) == VEC[v][2] - 1, rtag(VEC[v][4]),
                int'(burst_len_m1_o), VEC[v][2] - 1);
            chk(int'(burst_cnt_o) == VEC[v][3], rtag(VEC[v][4]), int'(burst_cnt_o), VEC[v][3]);
            drain(VEC[v][0]);
        end

        // R7: too-short totals are refused.
        for (int t = 0; t < 2; t++) begin
            pulse_start(t);
            chk(err_o == 1'b1, "R7", int'(err_o), 1);
            chk(desc_valid_o == 1'b0, "R7", int'(desc_valid_o), 0);
            @(negedge clk);
            chk(err_o == 1'b0, "R7", int'(err_o), 0);
            chk(desc_valid_o == 1'b0, "R7", int'(desc_valid_o), 0);
        end

        // R8 and R10: hold under back-pressure, ignore a second start.
        pulse_start(600000);
        for (int k = 0; k < 3; k++) begin
            if (k == 1) begin
                total_words_i = CNT_W'(20);
                start_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
            chk(desc_valid_o == 1'b1, "R8", int'(desc_valid_o), 1);
            chk(int'(seg_len_o) == MAXS, "R10", int'(seg_len_o), MAXS);
            chk(int'(burst_cnt_o) == 65535, "R8", int'(burst_cnt_o), 65535);
        end
        drain(600000);

        // R10 follow-up: the ignored start left nothing behind.
        @(negedge clk);
        chk(desc_valid_o == 1'b0, "R10", int'(desc_valid_o), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule